// File: doc/BRIEF.md
# Failsafe Sleep-Wake Power-Mode Controller

This block decides the power mode of a CAN node: sleep, standby or normal. It contains a single inactivity timer. The timer returns the node to sleep whenever the host processor stops servicing it. The timer length is a cycle-count parameter, so simulation can use a short period in place of the multi-minute value used in silicon.

Three separate paths lead back to sleep:

- **Power-up path.** After power-up the node starts in standby with a power-on flag set. The timer runs unconditionally until the host clears that flag or moves the node to normal mode.
- **Wake path.** When failsafe is enabled, a wake from sleep gives the host one timer period to move the node to normal mode.
- **Silence path.** When failsafe is enabled, a bus-silence indication that persists for one period in normal mode sends the node to sleep.

A power-on reset always re-arms the timer, even if software had disabled it.

Top module: `failsafe_pm`

## Requirements
- R1: After power-on reset the outputs are as follows: mode is standby (mode encoding 00 sleep, 01 standby, 10 normal), the power-on flag is 1, all wake flags are 0, the timer reads 0 and the timer-disable status is 0.
- R2: While the power-on flag is set in standby, the timer counts regardless of the disable bit and failsafe enable. The node enters sleep TIMEOUT cycles after entering standby, and the timer reads TIMEOUT-1 in the last standby cycle.
- R3: A host write to pwr_clr clears the power-on flag. With failsafe off, standby then holds and the timer reads 0.
- R4: In sleep, a bus wake, local wake or interrupt wake moves the node to standby. The event also sets wake-flag bit 0, 1 or 2 respectively.
- R5: Wake flags stay set until the host writes a 1 to the matching bit of wake_clr.
- R6: A normal request in standby moves the node to normal on the next edge only when all wake flags are 0. Otherwise the request is ignored.
- R7: With failsafe on and the timer enabled, standby without a normal request returns to sleep TIMEOUT cycles after it was entered.
- R8: With the timer-disable bit set and the power-on flag clear, the standby countdown does not run. A power-on reset clears the disable bit.
- R9: With failsafe on and the timer enabled, bus_silent held high for TIMEOUT consecutive cycles in normal mode sends the node to sleep. Any low cycle reloads the timer to 0.
- R10: A sleep request moves the node to sleep from standby or from normal.
- R11: The timer reads 0 in the cycle after any mode change and never exceeds TIMEOUT-1. The mode never takes the value 11.
- R12: In standby, a sleep request takes priority over a simultaneous normal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| fs_en | input | 1 | Failsafe enable control bit |
| dis_we | input | 1 | Write strobe for the timer-disable bit |
| dis_d | input | 1 | Value written to the timer-disable bit |
| pwr_clr | input | 1 | Host write clearing the power-on flag |
| wake_clr | input | 3 | Host write mask clearing wake flags |
| normal_req | input | 1 | Host request for normal mode |
| sleep_req | input | 1 | Host request for sleep mode |
| bus_wake | input | 1 | Bus wake pattern detected |
| local_wake | input | 1 | Local wake pin event |
| irq_wake | input | 1 | CAN interrupt wake event |
| bus_silent | input | 1 | Bus-silence indication |
| mode | output | 2 | Current mode: 00 sleep, 01 standby, 10 normal |
| pwr_flag | output | 1 | Power-on flag |
| wake_flags | output | 3 | Latched wake sources {irq, local, bus} |
| tmr_dis | output | 1 | Timer-disable bit status |
| timer_val | output | CW | Running inactivity timer value |

## Verification
The assertions assume that every input is synchronous to clk and stays stable across each rising edge. They also assume that por_n is the only reset, and that the mode register therefore starts from the standby encoding. The bench changes inputs one time unit after a rising edge and holds them for whole cycles. Wake events are driven only as single-cycle pulses, so each one produces exactly one set of wake flags and one transition. TIMEOUT is scaled to 8 so that every expiry path completes within a few dozen cycles.

// File: rtl/failsafe_pm.sv
module failsafe_pm #(
  parameter int unsigned TIMEOUT = 960_000_000,
  localparam int CW = $clog2(TIMEOUT)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          fs_en,
  input  logic          dis_we,
  input  logic          dis_d,
  input  logic          pwr_clr,
  input  logic [2:0]    wake_clr,
  input  logic          normal_req,
  input  logic          sleep_req,
  input  logic          bus_wake,
  input  logic          local_wake,
  input  logic          irq_wake,
  input  logic          bus_silent,
  output logic [1:0]    mode,
  output logic          pwr_flag,
  output logic [2:0]    wake_flags,
  output logic          tmr_dis,
  output logic [CW-1:0] timer_val
);
  localparam logic [1:0] SLEEP = 2'b00, STBY = 2'b01, NORM = 2'b10;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [1:0]    mode_q, mode_n;
  logic [CW-1:0] tmr_q;
  logic          pwr_q, dis_q, cnt_en, expire;
  logic [2:0]    wf_q;

  wire armed = fs_en && !dis_q;
  wire [2:0] wake_evt = {irq_wake, local_wake, bus_wake};

  assign cnt_en = (mode_q == STBY) ? (pwr_q || armed) :
                  (mode_q == NORM) ? (armed && bus_silent) : 1'b0;
  assign expire = cnt_en && (tmr_q == LAST);

  always_comb begin
    mode_n = mode_q;
    case (mode_q)
      SLEEP: if (|wake_evt) mode_n = STBY;
      STBY: begin
        if (sleep_req) mode_n = SLEEP;
        else if (normal_req && wf_q == 3'b000) mode_n = NORM;
        else if (expire) mode_n = SLEEP;
      end
      NORM: if (sleep_req || expire) mode_n = SLEEP;
      default: mode_n = SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= STBY;
      tmr_q  <= '0;
      pwr_q  <= 1'b1;
      wf_q   <= 3'b000;
      dis_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      tmr_q  <= (mode_n != mode_q || !cnt_en) ? '0 : tmr_q + 1'b1;
      if (pwr_clr) pwr_q <= 1'b0;
      wf_q   <= (wf_q & ~wake_clr) | (wake_evt & {3{mode_q == SLEEP}});
      if (dis_we) dis_q <= dis_d;
    end
  end

  assign mode       = mode_q;
  assign pwr_flag   = pwr_q;
  assign wake_flags = wf_q;
  assign tmr_dis    = dis_q;
  assign timer_val  = tmr_q;

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!por_n)
    mode != 2'b11);
  assert_timer_bound_R11: assert property (@(posedge clk) disable iff (!por_n)
    timer_val <= LAST);
  assert_timer_zero_on_change_R11: assert property (@(posedge clk) disable iff (!por_n)
    (mode != $past(mode)) |-> timer_val == '0);
  assert_normal_needs_clear_flags_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == STBY && wake_flags != 3'b000) |=> mode != NORM);
  assert_sleep_only_wakes_to_standby_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == SLEEP) |=> mode != NORM);
  assert_sleep_req_wins_R12: assert property (@(posedge clk) disable iff (!por_n)
    (mode != SLEEP && sleep_req) |=> mode == SLEEP);
endmodule

// File: tb/failsafe_pm_test.sv
module failsafe_pm_test;
  localparam int PERIOD = 10;
  localparam int T = 8;
  localparam int CW = $clog2(T);
  localparam int NV = 13;
  // {fs, sil, cw, lw, bw, wclr[2:0], pclr, nreq, sreq, mode[1:0], pwr, flags[2:0]}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b1, 2'b00,1'b1,3'b000}, // R10 sleep from standby
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0, 2'b00,1'b1,3'b000},
    {1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,1'b0,1'b0,1'b0, 2'b01,1'b1,3'b010}, // R4 local wake
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,1'b0,1'b0, 2'b01,1'b0,3'b010}, // R3 R5
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b1,1'b0, 2'b01,1'b0,3'b010}, // R6 refused
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b010,1'b0,1'b0,1'b0, 2'b01,1'b0,3'b000}, // R5 clear
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b1,1'b0, 2'b10,1'b0,3'b000}, // R6 accepted
    {1'b0,1'b1,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0, 2'b10,1'b0,3'b000}, // R9 failsafe off
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b1, 2'b00,1'b0,3'b000}, // R10 from normal
    {1'b0,1'b0,1'b1,1'b0,1'b1,3'b000,1'b0,1'b0,1'b0, 2'b01,1'b0,3'b101}, // R4 irq+bus
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b111,1'b0,1'b0,1'b0, 2'b01,1'b0,3'b000}, // R5
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b1,1'b1, 2'b00,1'b0,3'b000}, // R12
    {1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,1'b0,1'b0, 2'b00,1'b0,3'b000}
  };

  logic clk = 0, por_n = 0;
  logic fs_en = 0, dis_we = 0, dis_d = 0, pwr_clr = 0, normal_req = 0, sleep_req = 0;
  logic bus_wake = 0, local_wake = 0, irq_wake = 0, bus_silent = 0;
  logic [2:0] wake_clr = 0;
  logic [1:0] mode;
  logic pwr_flag, tmr_dis;
  logic [2:0] wake_flags;
  logic [CW-1:0] timer_val;
  int applied = 0, bad = 0;

  failsafe_pm #(.TIMEOUT(T)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    applied++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    {fs_en, dis_we, dis_d, pwr_clr, normal_req, sleep_req} = '0;
    {bus_wake, local_wake, irq_wake, bus_silent, wake_clr} = '0;
  endtask

  task automatic do_reset();
    idle();
    por_n = 0;
    tick(); tick();
    por_n = 1;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 mode", mode, 1); chk("R1 pwr", pwr_flag, 1);
    chk("R1 flags", wake_flags, 0); chk("R1 timer", timer_val, 0);
    chk("R1 dis", tmr_dis, 0);

    for (int i = 0; i < NV; i++) begin
      {fs_en, bus_silent, irq_wake, local_wake, bus_wake, wake_clr, pwr_clr,
       normal_req, sleep_req} = VEC[i][16:6];
      tick();
      chk($sformatf("vector %0d R4/R5/R6/R10/R12", i),
          {mode, pwr_flag, wake_flags}, VEC[i][5:0]);
    end

    // R2: power-up path ignores disable bit and failsafe off
    do_reset();
    dis_we = 1; dis_d = 1; tick(); idle();
    repeat (T - 2) tick();
    chk("R2 last standby mode", mode, 1); chk("R2 timer", timer_val, T - 1);
    tick();
    chk("R2 sleep", mode, 0); chk("R11 timer reload", timer_val, 0);
    chk("R8 dis set", tmr_dis, 1);
    do_reset();
    chk("R8 por clears dis", tmr_dis, 0);

    // R7: failsafe wake path
    sleep_req = 1; pwr_clr = 1; tick(); idle();
    chk("R3 pwr cleared", pwr_flag, 0);
    fs_en = 1; bus_wake = 1; tick(); bus_wake = 0;
    chk("R7 wake standby", mode, 1); chk("R11 timer zero", timer_val, 0);
    repeat (T - 1) tick();
    chk("R7 still standby", mode, 1); chk("R7 timer", timer_val, T - 1);
    tick();
    chk("R7 back to sleep", mode, 0);

    // R8: disable bit stops standby countdown
    dis_we = 1; dis_d = 1; tick(); dis_we = 0;
    bus_wake = 1; tick(); bus_wake = 0;
    repeat (T + 2) tick();
    chk("R8 standby holds", mode, 1); chk("R8 timer idle", timer_val, 0);

    // R9: silence path in normal mode
    wake_clr = 3'b111; dis_we = 1; dis_d = 0; tick();
    wake_clr = 0; dis_we = 0;
    normal_req = 1; tick(); normal_req = 0;
    chk("R6 normal", mode, 2);
    bus_silent = 1; repeat (T - 2) tick();
    chk("R9 timer", timer_val, T - 2);
    bus_silent = 0; tick();
    chk("R9 reload", timer_val, 0); chk("R9 still normal", mode, 2);
    bus_silent = 1; repeat (T - 1) tick();
    chk("R9 last normal", mode, 2);
    tick();
    chk("R9 sleep", mode, 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule